// File: doc/BRIEF.md
# Multiphase Counter-Ramp Pulse-Width Modulator

This block turns a digital control effort into switching pulses for a multiphase power converter. A fast clock drives one ramp counter per phase. Each counter runs from zero up to a programmable number of ticks and then starts again. At the start of each cycle the phase output goes high. It goes low once the counter reaches an on-time. That on-time comes from the shared control effort, which is an 11-bit fraction of full duty, plus a signed current-balance trim for that phase, multiplied by the period. One clock tick therefore changes the duty by 2^11/period effort LSBs. The output voltage step of the converter is the tick time times the switching frequency times the input voltage. For example, a 250 ps tick at 500 kHz from 12 V gives steps of 1.5 mV.

Each phase gives a one-clock strobe at the start of every cycle. The compensator and the sampling ADC use this strobe as their trigger. A sync pulse restarts every ramp at the same time. On sync, each phase loads its own programmable offset into its counter, so N phases can be spread evenly over the period and stay locked together. A new on-time and period take effect only at a cycle boundary. The trimmed duty is clamped to the range from zero to full, so 0 % and 100 % duty give clean constant outputs. The enable input forces every output low and leaves the counters running.

Top module: `dpwm_multiphase`

## Requirements
- R1: While reset is asserted, every PWM output and every start strobe is low. Each counter rests at zero and the held period is two ticks.
- R2: A cycle lasts exactly `period` ticks, with the counter running 0 .. period-1. A `period` value of 0 or 1 is treated as 2.
- R3: Within a cycle the phase output is high on the first `on` ticks and low on the rest, where on = floor(adj * P / 2048) and P is the effective period.
- R4: The adjusted duty is adj = effort + trim. Phase i's trim is the two's-complement field trim[i*8 +: 8], in units of effort LSB.
- R5: adj is clamped to 0..2048. A value at or below zero gives no high tick in the cycle, and 2048 or more gives a high output for the whole cycle.
- R6: Period, effort and trim are sampled only at a cycle start, meaning a wrap or a sync. A change in the middle of a cycle affects only later cycles.
- R7: While `enable` is low, every PWM output is low from the next clock on, and the ramp counters keep running.
- R8: The start strobe of a phase is high for one clock in the first cycle of each new period. A sync raises every phase's strobe in the clock after it.
- R9: A sync loads phase i's counter with phase_off[i*12 +: 12], or with zero if the offset is not below the effective period. The next strobe of that phase then follows P - offset ticks after the sync strobe.
- R10: Each phase applies its own trim and offset independently of the others, while sharing period, effort, enable and sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed ramp clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Output gate; low forces all outputs low |
| sync | input | 1 | Restart all ramps from their phase offsets |
| period | input | 12 | Cycle length in ticks |
| effort | input | 11 | Control effort, duty = effort/2048 |
| trim | input | 16 | Per-phase signed current-balance trim, 8 bits each |
| phase_off | input | 24 | Per-phase counter load value on sync, 12 bits each |
| pwm | output | 2 | Per-phase PWM output |
| sop | output | 2 | Per-phase start-of-period strobe |

## Verification
The checker watches several rules on every clock. It checks that the counter stays below the held period and that the on-time never exceeds it. It checks that the on-time changes only together with a start strobe, that a rising output edge under steady enable falls on a start strobe, that a low enable empties the outputs, and that a sync strobes every phase. Other behaviour can only be shown by the bench scenarios. These cover the exact high-tick count for each cycle from the effort, trim and clamp arithmetic, the cycle length and the treatment of small periods, the offset spacing after sync, and the rule that a mid-cycle change of effort leaves the current cycle's width unchanged.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Control effort is a pure fraction of full duty with this many bits.
    localparam int DUTY_FRAC_W = 11;
    localparam int DUTY_FULL   = 1 << DUTY_FRAC_W;

    // What the ramp does at the next edge.
    typedef enum logic [1:0] {
        EV_RUN  = 2'd0,
        EV_WRAP = 2'd1,
        EV_SYNC = 2'd2
    } ramp_event_e;

endpackage

// File: rtl/dpwm_ontime.sv
// Combinational on-time calculation: trim, clamp, scale by period.
module dpwm_ontime
    import dpwm_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int TRIM_W = 8
) (
    input  logic [DUTY_FRAC_W-1:0] effort,
    input  logic [TRIM_W-1:0]      trim,
    input  logic [CNT_W-1:0]       per,
    output logic [CNT_W-1:0]       on_ticks
);
    localparam int ADJ_W  = ((TRIM_W + 1) > (DUTY_FRAC_W + 2)) ? (TRIM_W + 2) : (DUTY_FRAC_W + 3);
    localparam int CLMP_W = DUTY_FRAC_W + 1;
    localparam int PROD_W = CLMP_W + CNT_W;

    logic signed [ADJ_W-1:0] sum_s;
    logic [CLMP_W-1:0]       adj;
    logic [PROD_W-1:0]       prod;

    always_comb begin
        sum_s = $signed({{(ADJ_W-DUTY_FRAC_W){1'b0}}, effort})
              + $signed({{(ADJ_W-TRIM_W){trim[TRIM_W-1]}}, trim});
        if (sum_s < 0) begin
            adj = '0;
        end else if (sum_s > $signed(ADJ_W'(DUTY_FULL))) begin
            adj = CLMP_W'(DUTY_FULL);
        end else begin
            adj = CLMP_W'(sum_s);
        end
        prod     = PROD_W'(adj) * PROD_W'(per);
        on_ticks = CNT_W'(prod >> DUTY_FRAC_W);
    end

endmodule

// File: rtl/dpwm_phase_engine.sv
// One ramp counter with boundary-latched on-time and registered output.
module dpwm_phase_engine
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sync,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] on_in,
    input  logic [CNT_W-1:0] offset,
    output logic             pwm,
    output logic             sop,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] on_o,
    output logic [CNT_W-1:0] per_o
);
    localparam logic [CNT_W-1:0] PER_RST = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] on;
        logic             pwm;
        logic             sop;
    } eng_state_t;

    eng_state_t  st_d, st_q;
    ramp_event_e ev;

    always_comb begin
        if (sync) begin
            ev = EV_SYNC;
        end else if (st_q.cnt >= (st_q.per - ONE)) begin
            ev = EV_WRAP;
        end else begin
            ev = EV_RUN;
        end

        st_d = st_q;
        unique case (ev)
            EV_SYNC: begin
                st_d.cnt = (offset < per_in) ? offset : '0;
                st_d.per = per_in;
                st_d.on  = on_in;
                st_d.sop = 1'b1;
            end
            EV_WRAP: begin
                st_d.cnt = '0;
                st_d.per = per_in;
                st_d.on  = on_in;
                st_d.sop = 1'b1;
            end
            default: begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.sop = 1'b0;
            end
        endcase
        st_d.pwm = enable && (st_d.cnt < st_d.on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.per <= PER_RST;
            st_q.on  <= '0;
            st_q.pwm <= 1'b0;
            st_q.sop <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm   = st_q.pwm;
    assign sop   = st_q.sop;
    assign cnt_o = st_q.cnt;
    assign on_o  = st_q.on;
    assign per_o = st_q.per;

endmodule

// File: rtl/dpwm_multiphase.sv
module dpwm_multiphase
    import dpwm_pkg::*;
#(
    parameter int NPH    = 2,
    parameter int CNT_W  = 12,
    parameter int TRIM_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   sync,
    input  logic [CNT_W-1:0]       period,
    input  logic [DUTY_FRAC_W-1:0] effort,
    input  logic [NPH*TRIM_W-1:0]  trim,
    input  logic [NPH*CNT_W-1:0]   phase_off,
    output logic [NPH-1:0]         pwm,
    output logic [NPH-1:0]         sop
);
    localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(2);

    logic [CNT_W-1:0]     per_eff;
    logic [NPH*CNT_W-1:0] on_all;
    logic [NPH*CNT_W-1:0] cnt_all;
    logic [NPH*CNT_W-1:0] per_all;

    assign per_eff = (period < PER_MIN) ? PER_MIN : period;

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        logic [CNT_W-1:0] on_next;

        dpwm_ontime #(
            .CNT_W (CNT_W),
            .TRIM_W(TRIM_W)
        ) u_ontime (
            .effort  (effort),
            .trim    (trim[i*TRIM_W +: TRIM_W]),
            .per     (per_eff),
            .on_ticks(on_next)
        );

        dpwm_phase_engine #(
            .CNT_W(CNT_W)
        ) u_engine (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(enable),
            .sync  (sync),
            .per_in(per_eff),
            .on_in (on_next),
            .offset(phase_off[i*CNT_W +: CNT_W]),
            .pwm   (pwm[i]),
            .sop   (sop[i]),
            .cnt_o (cnt_all[i*CNT_W +: CNT_W]),
            .on_o  (on_all[i*CNT_W +: CNT_W]),
            .per_o (per_all[i*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
    parameter int NPH   = 2,
    parameter int CNT_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 sync,
    input logic [NPH-1:0]       pwm,
    input logic [NPH-1:0]       sop,
    input logic [NPH*CNT_W-1:0] on_all,
    input logic [NPH*CNT_W-1:0] cnt_all,
    input logic [NPH*CNT_W-1:0] per_all
);
    logic en_d1, en_d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d1 <= 1'b0;
            en_d2 <= 1'b0;
        end else begin
            en_d1 <= enable;
            en_d2 <= en_d1;
        end
    end

    // R8: a sync strobes every phase in the following clock
    a_r8_sync_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (&sop));

    for (genvar i = 0; i < NPH; i++) begin : g_chk
        // R2: counter stays inside the held period
        a_r2_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_all[i*CNT_W +: CNT_W] < per_all[i*CNT_W +: CNT_W]);
        // R5: clamped on-time never exceeds the period
        a_r5_on_within_period: assert property (@(posedge clk) disable iff (!rst_n)
            on_all[i*CNT_W +: CNT_W] <= per_all[i*CNT_W +: CNT_W]);
        // R6: on-time only changes together with a start strobe
        a_r6_on_held: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(on_all[i*CNT_W +: CNT_W]) |-> sop[i]);
        // R3: under steady enable the output only rises at a cycle start
        a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pwm[i]) && en_d2) |-> sop[i]);
        // R7: disabled output goes low at the next clock
        a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> !pwm[i]);
    end

endmodule

bind dpwm_multiphase dpwm_checker #(
    .NPH  (NPH),
    .CNT_W(CNT_W)
) u_dpwm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .sync   (sync),
    .pwm    (pwm),
    .sop    (sop),
    .on_all (on_all),
    .cnt_all(cnt_all),
    .per_all(per_all)
);

// File: tb/test_dpwm_multiphase.sv
module test_dpwm_multiphase;
    localparam int NPH    = 2;
    localparam int CNT_W  = 12;
    localparam int TRIM_W = 8;
    localparam int FRAC   = 11;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  enable = 1'b0;
    logic                  sync = 1'b0;
    logic [CNT_W-1:0]      period = '0;
    logic [FRAC-1:0]       effort = '0;
    logic [NPH*TRIM_W-1:0] trim = '0;
    logic [NPH*CNT_W-1:0]  phase_off = '0;
    logic [NPH-1:0]        pwm;
    logic [NPH-1:0]        sop;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    dpwm_multiphase #(.NPH(NPH), .CNT_W(CNT_W), .TRIM_W(TRIM_W)) i_dpwm_multiphase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync(sync), .period(period),
        .effort(effort), .trim(trim), .phase_off(phase_off), .pwm(pwm), .sop(sop));

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired: actual=%0d expected<%0d cycles", cycles, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_per(input int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int ref_on(input int eff, input int tr, input int p);
        int a = eff + tr;
        if (a < 0) a = 0;
        if (a > 2048) a = 2048;
        return (a * ref_per(p)) >>> FRAC;
    endfunction

    task automatic set_phase(input int i, input int tr, input int off);
        trim[i*TRIM_W +: TRIM_W]   = TRIM_W'(tr);
        phase_off[i*CNT_W +: CNT_W] = CNT_W'(off);
    endtask

    // Pulse sync; ends at the negedge right after the sync edge.
    task automatic do_sync();
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        chk(sop == '1, "R8 sync strobe", int'(sop), (1 << NPH) - 1);
    endtask

    // Starting at a negedge, count the ticks until each phase strobes again (R9).
    task automatic check_offsets(input int p, input int off0, input int off1);
        int d[NPH];
        int offs[NPH];
        int k = 0;
        offs[0] = off0;
        offs[1] = off1;
        for (int i = 0; i < NPH; i++) d[i] = 0;
        while ((d[0] == 0 || d[1] == 0) && k < 5000) begin
            @(negedge clk);
            k++;
            for (int i = 0; i < NPH; i++) if (d[i] == 0 && sop[i]) d[i] = k;
        end
        for (int i = 0; i < NPH; i++) begin
            int pe = ref_per(p);
            int exp = (offs[i] < pe) ? pe - offs[i] : pe;
            chk(d[i] == exp, (i == 0) ? "R9 offset spacing" : "R10 R9 phase1 offset spacing", d[i], exp);
        end
    endtask

    // Measure one complete cycle of phase i: length and high ticks.
    task automatic measure(input int i, output int len, output int hi);
        while (!sop[i]) @(negedge clk);
        @(negedge clk);
        while (!sop[i]) @(negedge clk);
        len = 0;
        hi = 0;
        do begin
            hi += int'(pwm[i]);
            len++;
            @(negedge clk);
        end while (!sop[i]);
    endtask

    task automatic check_cycle(input int i, input int p, input int eff, input int tr, input string tag);
        int len, hi;
        measure(i, len, hi);
        chk(len == ref_per(p), {"R2 ", tag}, len, ref_per(p));
        chk(hi == ref_on(eff, tr, p), {"R3 ", tag}, hi, ref_on(eff, tr, p));
    endtask

    initial begin
        int len, hi, p, eff, t0, t1, o0, o1;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pwm == '0, "R1 pwm low in reset", int'(pwm), 0);
        chk(sop == '0, "R1 sop low in reset", int'(sop), 0);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;

        // Directed: half duty, equal phases
        period = 12'd100; effort = 11'd1024;
        set_phase(0, 0, 0); set_phase(1, 0, 50);
        do_sync();
        check_offsets(100, 0, 50);
        check_cycle(0, 100, 1024, 0, "half duty ph0");
        check_cycle(1, 100, 1024, 0, "half duty ph1");

        // R4 / R10: opposite trims on the two phases
        set_phase(0, 60, 0); set_phase(1, -60, 50);
        check_cycle(0, 100, 1024, 60, "R4 positive trim");
        check_cycle(1, 100, 1024, -60, "R4 R10 negative trim");

        // R5: clamp at both ends
        effort = 11'd2047; set_phase(0, 5, 0); set_phase(1, -128, 50);
        check_cycle(0, 100, 2047, 5, "R5 full clamp");
        check_cycle(1, 100, 2047, -128, "R5 trimmed below full");
        effort = 11'd3; set_phase(0, -10, 0);
        check_cycle(0, 100, 3, -10, "R5 zero clamp");

        // R2: small period treated as two ticks
        period = 12'd0; effort = 11'd1024; set_phase(0, 0, 0);
        check_cycle(0, 0, 1024, 0, "R2 period zero");
        period = 12'd1;
        check_cycle(0, 1, 1024, 0, "R2 period one");

        // R9: offset not below the period loads zero
        period = 12'd40; set_phase(0, 0, 40); set_phase(1, 0, 39);
        do_sync();
        check_offsets(40, 40, 39);

        // R6: mid-cycle effort change only affects later cycles
        period = 12'd100; effort = 11'd1024; set_phase(0, 0, 0); set_phase(1, 0, 50);
        measure(0, len, hi);
        hi = 0; len = 0;
        do begin
            hi += int'(pwm[0]);
            len++;
            if (len == 10) effort = 11'd256;
            @(negedge clk);
        end while (!sop[0]);
        chk(hi == 50, "R6 width held in cycle", hi, 50);
        hi = 0; len = 0;
        do begin
            hi += int'(pwm[0]);
            len++;
            @(negedge clk);
        end while (!sop[0]);
        chk(hi == ref_on(256, 0, 100), "R6 new width next cycle", hi, ref_on(256, 0, 100));

        // R7: enable low forces output low, counter keeps running
        effort = 11'd2000;
        while (!pwm[0]) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(pwm == '0, "R7 output low next clock", int'(pwm), 0);
        measure(0, len, hi);
        chk(hi == 0, "R7 no pulse while disabled", hi, 0);
        chk(len == 100, "R7 counter keeps running", len, 100);
        enable = 1'b1;

        // Random configurations
        for (int r = 0; r < 25; r++) begin
            p   = 2 + int'($urandom % 300);
            eff = int'($urandom % 2048);
            t0  = int'($urandom % 256) - 128;
            t1  = int'($urandom % 256) - 128;
            o0  = int'($urandom % (p + 20));
            o1  = int'($urandom % (p + 20));
            period = CNT_W'(p); effort = FRAC'(eff);
            set_phase(0, t0, o0); set_phase(1, t1, o1);
            do_sync();
            check_offsets(p, o0, o1);
            check_cycle(0, p, eff, t0, "random ph0");
            check_cycle(1, p, eff, t1, "R10 random ph1");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule